// File: doc/BRIEF.md
# Nonvolatile Array Control Register with Pulse Sequencer

This block holds the control and status word for an on-chip nonvolatile array and times the program and erase pulses sent to it. Three mode bits (arm, erase-select, write-mode) are decoded into one of four operating modes: standard, non-verify, program and erase. The mode also sets which read path the array may use. Selecting program or erase does not start anything. A separate one-cycle command strobe launches a pulse. The pulse length comes from a 2-bit width field and is clamped to a per-operation maximum. A busy flag stays high for the whole pulse.

The block also keeps a write-only read-protect bit, which only code fetched from the array itself may change. It reports a live supply-good status and a sticky fault flag that records any supply dropout during a pulse. It keeps a running total of pulse time for each operation type. When a total reaches its budget, the running pulse is cut short, later commands of that type are refused, and an error flag is raised. The cell array and the high-voltage generator are outside the block; they see only the pulse-enable and operation outputs.

Top module: `flash_ctl_seq`

## Requirements
- R1: After reset the read word is all zero (standard mode, width code 0, not busy, no faults), `read_sel` is 0, `direct_ok` is 1 and the protect bit is 1, so `prot_active` equals `prot_global_en`.
- R2: Mode decode from the write-mode bit (bit 2), erase-select (bit 1) and arm (bit 0):
  - write-mode 0 gives standard, whatever the other two bits are;
  - write-mode 1 with arm 0 gives non-verify;
  - write-mode 1, arm 1, erase-select 0 gives program;
  - write-mode 1, arm 1, erase-select 1 gives erase.
  - `read_sel` is 0 (normal, direct or indirect) in standard, 1 (normal, indirect only) in non-verify, 2 (program-verify) in program and 3 (erase-verify) in erase. `direct_ok` is 1 only in standard.
- R3: Writing the mode bits never starts a pulse. `cmd_go` starts a pulse only in program or erase mode and only while not busy; in standard or non-verify mode it has no effect.
- R4: A pulse of code c (bits 4:3) keeps busy (read bit 6) high for exactly min(UNIT_US·2^c, MAX_US)·CLK_KHZ/1000 cycles (at least 1), using the unit and maximum of the current operation. The busy bit cannot be written.
- R5: Writes are whole words. A write with bit 2 = 1 loads bits 4:0. A write with bit 2 = 0 in a writing mode clears bits 2:0 and keeps the width. A write with bit 2 = 0 in standard mode leaves bits 4:0 unchanged. Any write while busy leaves bits 4:0 unchanged.
- R6: The protect bit (write bit 5) reads back as 0, resets to 1, and changes in any mode, but only on a write with `wr_from_array` = 1. `prot_active` is protect AND `prot_global_en`.
- R7: Read bit 7 equals `vpp_ok` while the write-mode bit is set and 0 otherwise. Read bit 8 is set by any cycle of a pulse with `vpp_ok` = 0, and is cleared when the next command is accepted.
- R8: Pulse cycles are summed separately for program and erase. A pulse ends early on the cycle its total reaches PRG_SUM_US or ERS_SUM_US (scaled to cycles). A command whose total is already at the budget is refused and sets the error flag (read bit 9).
- R9: A write that leaves writing mode clears both totals and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Word write strobe |
| reg_wdata | input | DATA_W | Write data |
| wr_from_array | input | 1 | Current write comes from an instruction fetched from the array |
| reg_rdata | output | DATA_W | Read word: control fields and status |
| cmd_go | input | 1 | Command strobe that starts the selected operation |
| prot_global_en | input | 1 | Global protection enable |
| vpp_ok | input | 1 | Programming supply above threshold |
| pulse_on | output | 1 | High-voltage pulse enable to the array |
| pulse_erase | output | 1 | Running pulse is an erase (0: program) |
| read_sel | output | 2 | Allowed read path |
| direct_ok | output | 1 | Direct memory reads allowed |
| prot_active | output | 1 | Read protection in force |

## Verification
The bench sets CLK_KHZ to 1000, so one microsecond is one cycle. Program uses unit 2, maximum 10 and budget 30. Erase uses unit 4, maximum 20 and budget 50. With these values every width code is measured in a few cycles, and the top code of each operation hits its clamp. Both totals reach their budgets within a handful of pulses. The third erase pulse is cut to 10 cycles, which exercises the early stop together with the refusal and error flag that follow.

// File: rtl/flash_ctl_pkg.sv
`timescale 1ns/1ps
package flash_ctl_pkg;

   typedef enum logic [1:0] {
      MODE_STD   = 2'd0,
      MODE_NOVFY = 2'd1,
      MODE_PROG  = 2'd2,
      MODE_ERASE = 2'd3
   } fmode_t;

   typedef enum logic [1:0] {
      RD_ANY  = 2'd0,
      RD_IND  = 2'd1,
      RD_PVFY = 2'd2,
      RD_EVFY = 2'd3
   } rdpath_t;

   // Field positions of the control and status word
   localparam int B_ARM   = 0;
   localparam int B_ERS   = 1;
   localparam int B_WM    = 2;
   localparam int B_WID   = 3;  // two bits: 4:3
   localparam int B_PROT  = 5;
   localparam int B_BUSY  = 6;
   localparam int B_VLIVE = 7;
   localparam int B_VFLT  = 8;
   localparam int B_BERR  = 9;
   localparam int FIELD_TOP = 9;

   function automatic longint us_to_cyc(longint us, longint khz);
      return (us * khz) / 1000;
   endfunction

   // Clamped pulse length in cycles for one width code
   function automatic longint pulse_cyc(longint unit_us, int code, longint max_us, longint khz);
      longint w;
      longint m;
      w = us_to_cyc(unit_us << code, khz);
      m = us_to_cyc(max_us, khz);
      if (m < 1) m = 1;
      if (w > m) w = m;
      if (w < 1) w = 1;
      return w;
   endfunction

   function automatic longint max2(longint a, longint b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/flash_mode_decode.sv
`timescale 1ns/1ps
module flash_mode_decode
   import flash_ctl_pkg::*;
(
   input  logic    arm,
   input  logic    ers,
   input  logic    wm,
   output fmode_t  mode,
   output rdpath_t rd,
   output logic    direct_ok
);

   always_comb begin
      if (!wm)       mode = MODE_STD;
      else if (!arm) mode = MODE_NOVFY;
      else if (ers)  mode = MODE_ERASE;
      else           mode = MODE_PROG;
   end

   always_comb begin
      unique case (mode)
         MODE_STD:   rd = RD_ANY;
         MODE_NOVFY: rd = RD_IND;
         MODE_PROG:  rd = RD_PVFY;
         default:    rd = RD_EVFY;
      endcase
   end

   assign direct_ok = (rd == RD_ANY);

   // R2: decoder output consistency, checked combinationally
   always_comb begin
      if (wm && arm) begin
         a_verify_path_r2: assert (rd == RD_PVFY || rd == RD_EVFY);
      end
   end

endmodule

// File: rtl/flash_pulse_timer.sv
`timescale 1ns/1ps
module flash_pulse_timer #(
   parameter int PW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_erase,
   input  logic [PW_W-1:0] width,
   input  logic            stop,
   input  logic            vpp_ok,
   output logic            busy,
   output logic            op_erase,
   output logic            vpp_fault
);

   logic [PW_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         rem_q     <= '0;
         op_erase  <= 1'b0;
         vpp_fault <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         rem_q     <= width;
         op_erase  <= start_erase;
         vpp_fault <= 1'b0;
      end else if (busy) begin
         if (!vpp_ok) vpp_fault <= 1'b1;
         if (rem_q == PW_W'(1) || stop) begin
            busy  <= 1'b0;
            rem_q <= '0;
         end else begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   p_busy_has_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem_q != '0));

   p_vpp_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && !vpp_ok) |=> vpp_fault);

   p_vpp_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_fault && !start) |=> vpp_fault);

endmodule

// File: rtl/flash_pulse_budget.sv
`timescale 1ns/1ps
module flash_pulse_budget #(
   parameter int     CNT_W   = 16,
   parameter longint PRG_LIM = 100,
   parameter longint ERS_LIM = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       busy,
   input  logic       op_erase,
   output logic [1:0] full,
   output logic       stop
);

   logic [1:0] last;

   for (genvar g = 0; g < 2; g++) begin : g_op
      localparam longint LIM_L = (g == 1) ? ERS_LIM : PRG_LIM;
      localparam logic [CNT_W:0] LIM = LIM_L[CNT_W:0];
      logic [CNT_W-1:0] acc_q;
      logic             mine;

      assign mine = busy && (op_erase == (g == 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               acc_q <= '0;
         else if (clear)           acc_q <= '0;
         else if (mine && !full[g]) acc_q <= acc_q + 1'b1;
      end

      assign full[g] = ({1'b0, acc_q} >= LIM);
      assign last[g] = (({1'b0, acc_q} + 1'b1) >= LIM);

      p_acc_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
         {1'b0, acc_q} <= LIM);

      p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> (acc_q == '0));
   end

   assign stop = busy && (op_erase ? last[1] : last[0]);

endmodule

// File: rtl/flash_ctl_seq.sv
`timescale 1ns/1ps
module flash_ctl_seq
   import flash_ctl_pkg::*;
#(
   parameter int     DATA_W      = 16,
   parameter longint CLK_KHZ     = 20000,
   parameter longint PRG_UNIT_US = 16,
   parameter longint PRG_MAX_US  = 128,
   parameter longint PRG_SUM_US  = 2500,
   parameter longint ERS_UNIT_US = 1250,
   parameter longint ERS_MAX_US  = 10000,
   parameter longint ERS_SUM_US  = 30000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              wr_from_array,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cmd_go,
   input  logic              prot_global_en,
   input  logic              vpp_ok,
   output logic              pulse_on,
   output logic              pulse_erase,
   output logic [1:0]        read_sel,
   output logic              direct_ok,
   output logic              prot_active
);

   localparam longint PRG_TOP = pulse_cyc(PRG_UNIT_US, 3, PRG_MAX_US, CLK_KHZ);
   localparam longint ERS_TOP = pulse_cyc(ERS_UNIT_US, 3, ERS_MAX_US, CLK_KHZ);
   localparam int     PW_W    = $clog2(max2(PRG_TOP, ERS_TOP) + 1);
   localparam longint PRG_LIM = max2(us_to_cyc(PRG_SUM_US, CLK_KHZ), 1);
   localparam longint ERS_LIM = max2(us_to_cyc(ERS_SUM_US, CLK_KHZ), 1);
   localparam int     CNT_W   = $clog2(max2(PRG_LIM, ERS_LIM) + 1);

   // Elaboration-time parameter checks
   if (DATA_W <= FIELD_TOP) begin : g_bad_width
      $error("DATA_W too small for the status fields");
   end
   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be positive");
   end
   if (PRG_UNIT_US < 1 || ERS_UNIT_US < 1) begin : g_bad_unit
      $error("pulse units must be positive");
   end

   // Pulse length tables, one entry per width code
   logic [PW_W-1:0] prg_tab [4];
   logic [PW_W-1:0] ers_tab [4];
   for (genvar c = 0; c < 4; c++) begin : g_tab
      localparam longint PC = pulse_cyc(PRG_UNIT_US, c, PRG_MAX_US, CLK_KHZ);
      localparam longint EC = pulse_cyc(ERS_UNIT_US, c, ERS_MAX_US, CLK_KHZ);
      assign prg_tab[c] = PC[PW_W-1:0];
      assign ers_tab[c] = EC[PW_W-1:0];
   end

   logic       arm_q, ers_q, wm_q, prot_q, berr_q;
   logic [1:0] wid_q;
   fmode_t     mode;
   rdpath_t    rd;
   logic       busy, op_erase, vpp_fault, stop;
   logic [1:0] full;
   logic       op_mode, want_erase, accept, refuse, leave, wr_ok;
   logic [PW_W-1:0] width;

   flash_mode_decode u_dec (
      .arm       (arm_q),
      .ers       (ers_q),
      .wm        (wm_q),
      .mode      (mode),
      .rd        (rd),
      .direct_ok (direct_ok)
   );

   assign op_mode    = (mode == MODE_PROG) || (mode == MODE_ERASE);
   assign want_erase = (mode == MODE_ERASE);
   assign accept     = cmd_go && !busy && op_mode && !full[want_erase];
   assign refuse     = cmd_go && !busy && op_mode &&  full[want_erase];
   assign wr_ok      = reg_wr && !busy;
   assign leave      = wr_ok && wm_q && !reg_wdata[B_WM];
   assign width      = want_erase ? ers_tab[wid_q] : prg_tab[wid_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         ers_q <= 1'b0;
         wm_q  <= 1'b0;
         wid_q <= 2'd0;
      end else if (wr_ok) begin
         if (reg_wdata[B_WM]) begin
            arm_q <= reg_wdata[B_ARM];
            ers_q <= reg_wdata[B_ERS];
            wm_q  <= 1'b1;
            wid_q <= reg_wdata[B_WID +: 2];
         end else if (wm_q) begin
            arm_q <= 1'b0;
            ers_q <= 1'b0;
            wm_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        prot_q <= 1'b1;
      else if (reg_wr && wr_from_array)  prot_q <= reg_wdata[B_PROT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      berr_q <= 1'b0;
      else if (leave)  berr_q <= 1'b0;
      else if (refuse) berr_q <= 1'b1;
   end

   flash_pulse_timer #(.PW_W(PW_W)) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_erase (want_erase),
      .width       (width),
      .stop        (stop),
      .vpp_ok      (vpp_ok),
      .busy        (busy),
      .op_erase    (op_erase),
      .vpp_fault   (vpp_fault)
   );

   flash_pulse_budget #(
      .CNT_W   (CNT_W),
      .PRG_LIM (PRG_LIM),
      .ERS_LIM (ERS_LIM)
   ) u_bud (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (leave),
      .busy     (busy),
      .op_erase (op_erase),
      .full     (full),
      .stop     (stop)
   );

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[B_ARM]     = arm_q;
      reg_rdata[B_ERS]     = ers_q;
      reg_rdata[B_WM]      = wm_q;
      reg_rdata[B_WID +: 2] = wid_q;
      reg_rdata[B_BUSY]    = busy;
      reg_rdata[B_VLIVE]   = wm_q && vpp_ok;
      reg_rdata[B_VFLT]    = vpp_fault;
      reg_rdata[B_BERR]    = berr_q;
   end

   assign pulse_on    = busy;
   assign pulse_erase = op_erase;
   assign read_sel    = rd;
   assign prot_active = prot_q && prot_global_en;

   p_start_needs_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(mode) == MODE_PROG || $past(mode) == MODE_ERASE));

   p_std_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_WM] |-> (direct_ok && read_sel == 2'd0));

   p_fields_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(reg_rdata[4:0]));

   p_prot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && wr_from_array) |=> $stable(prot_q));

   p_refuse_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (!busy && berr_q));

endmodule

// File: tb/flash_ctl_seq_test.sv
`timescale 1ns/1ps
module flash_ctl_seq_test;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic          wr_from_array = 1'b0;
   logic [DW-1:0] reg_rdata;
   logic          cmd_go = 1'b0;
   logic          prot_global_en = 1'b1;
   logic          vpp_ok = 1'b1;
   logic          pulse_on, pulse_erase, direct_ok, prot_active;
   logic [1:0]    read_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   flash_ctl_seq #(
      .DATA_W(DW), .CLK_KHZ(1000),
      .PRG_UNIT_US(2), .PRG_MAX_US(10), .PRG_SUM_US(30),
      .ERS_UNIT_US(4), .ERS_MAX_US(20), .ERS_SUM_US(50)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .wr_from_array(wr_from_array), .reg_rdata(reg_rdata), .cmd_go(cmd_go),
      .prot_global_en(prot_global_en), .vpp_ok(vpp_ok), .pulse_on(pulse_on),
      .pulse_erase(pulse_erase), .read_sel(read_sel), .direct_ok(direct_ok),
      .prot_active(prot_active)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk(bit arm, bit ers, bit wm, int wid, bit prot);
      logic [DW-1:0] d;
      d = '0;
      d[0] = arm; d[1] = ers; d[2] = wm; d[4:3] = wid[1:0]; d[5] = prot;
      return d;
   endfunction

   function automatic int exp_sel(bit arm, bit ers, bit wm);
      if (!wm) return 0;
      if (!arm) return 1;
      return ers ? 3 : 2;
   endfunction

   function automatic int exp_width(bit erase, int code);
      int w;
      w = erase ? (4 << code) : (2 << code);
      if (erase && w > 20) w = 20;
      if (!erase && w > 10) w = 10;
      return w;
   endfunction

   task automatic wr(logic [DW-1:0] d, bit from_arr);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d; wr_from_array = from_arr;
      @(negedge clk);
      reg_wr = 1'b0; wr_from_array = 1'b0;
   endtask

   task automatic go_count(output int n);
      @(negedge clk);
      cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      n = 0;
      while (reg_rdata[6] && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit m_arm, m_ers, m_wm, m_prot;
      int m_wid, n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", int'(reg_rdata), 0);
      check("R1 read_sel", int'(read_sel), 0);
      check("R1 direct_ok", int'(direct_ok), 1);
      check("R1 prot_active", int'(prot_active), 1);

      // R2/R5/R6 random register writes against a bench model
      m_arm = 0; m_ers = 0; m_wm = 0; m_wid = 0; m_prot = 1;
      for (int i = 0; i < 40; i++) begin
         logic [DW-1:0] d;
         bit fa, ge;
         d  = DW'($urandom);
         fa = 1'($urandom);
         ge = 1'($urandom);
         prot_global_en = ge;
         wr(d, fa);
         if (d[2]) begin
            m_arm = d[0]; m_ers = d[1]; m_wm = 1; m_wid = int'(d[4:3]);
         end else if (m_wm) begin
            m_arm = 0; m_ers = 0; m_wm = 0;
         end
         if (fa) m_prot = d[5];
         check("R5 fields", int'(reg_rdata[5:0]), int'(mk(m_arm, m_ers, m_wm, m_wid, 0)));
         check("R2 read_sel", int'(read_sel), exp_sel(m_arm, m_ers, m_wm));
         check("R2 direct_ok", int'(direct_ok), (m_wm ? 0 : 1));
         check("R6 prot_active", int'(prot_active), int'(m_prot & ge));
      end
      prot_global_en = 1'b1;
      wr(mk(0, 0, 0, 0, 1), 1);
      wr(mk(0, 0, 0, 0, 1), 0);

      // R5 standard mode keeps fields on a write without write-mode
      wr(mk(1, 1, 0, 2, 0), 0);
      check("R5 std write ignored", int'(reg_rdata[4:0]), int'(mk(0, 0, 0, m_wid, 0) & 16'h1f));
      // R3 commands outside program/erase do nothing
      go_count(n);
      check("R3 go in standard", n, 0);
      wr(mk(0, 0, 1, 1, 0), 0);
      go_count(n);
      check("R3 go in non-verify", n, 0);
      wr(mk(1, 0, 1, 1, 0), 0);
      repeat (5) @(negedge clk);
      check("R3 select does not start", int'(reg_rdata[6]), 0);
      check("R3 pulse_on idle", int'(pulse_on), 0);
      // R4 pulse lengths
      go_count(n);
      check("R4 program code1", n, exp_width(0, 1));
      wr(mk(1, 0, 1, 3, 0), 0);
      go_count(n);
      check("R4 program clamp", n, exp_width(0, 3));
      wr(mk(1, 1, 1, 0, 0), 0);
      go_count(n);
      check("R4 erase code0", n, exp_width(1, 0));
      wr(mk(1, 1, 1, 3, 0) | 16'h0040, 0);
      check("R4 busy not writable", int'(reg_rdata[6]), 0);
      go_count(n);
      check("R4 erase clamp", n, exp_width(1, 3));
      wr(mk(0, 0, 0, 0, 0), 0);

      // R5 writes while busy are ignored
      wr(mk(1, 0, 1, 3, 0), 0);
      @(negedge clk); cmd_go = 1'b1;
      @(negedge clk); cmd_go = 1'b0;
      check("R4 pulse_erase low", int'(pulse_erase), 0);
      reg_wr = 1'b1; reg_wdata = mk(1, 1, 1, 0, 0);
      @(negedge clk); reg_wr = 1'b0;
      while (reg_rdata[6]) @(negedge clk);
      check("R5 busy write ignored", int'(reg_rdata[4:0]), int'(mk(1, 0, 1, 3, 0)));
      wr(mk(0, 0, 0, 0, 0), 0);

      // R6 protect bit
      wr(mk(0, 0, 0, 0, 0), 0);
      check("R6 protect without array", int'(prot_active), 1);
      wr(mk(0, 0, 0, 0, 0), 1);
      check("R6 protect from array", int'(prot_active), 0);
      check("R6 protect reads zero", int'(reg_rdata[5]), 0);
      wr(mk(0, 0, 0, 0, 1), 1);
      check("R6 protect set", int'(prot_active), 1);
      prot_global_en = 1'b0;
      @(negedge clk);
      check("R6 global off", int'(prot_active), 0);
      prot_global_en = 1'b1;

      // R7 supply status
      vpp_ok = 1'b1;
      @(negedge clk);
      check("R7 live in standard", int'(reg_rdata[7]), 0);
      wr(mk(1, 0, 1, 3, 0), 0);
      check("R7 live high", int'(reg_rdata[7]), 1);
      vpp_ok = 1'b0;
      @(negedge clk);
      check("R7 live low", int'(reg_rdata[7]), 0);
      vpp_ok = 1'b1;
      @(negedge clk); cmd_go = 1'b1;
      @(negedge clk); cmd_go = 1'b0;
      @(negedge clk); vpp_ok = 1'b0;
      @(negedge clk); vpp_ok = 1'b1;
      while (reg_rdata[6]) @(negedge clk);
      repeat (2) @(negedge clk);
      check("R7 sticky set", int'(reg_rdata[8]), 1);
      @(negedge clk); cmd_go = 1'b1;
      @(negedge clk); cmd_go = 1'b0;
      check("R7 sticky cleared", int'(reg_rdata[8]), 0);
      while (reg_rdata[6]) @(negedge clk);
      wr(mk(0, 0, 0, 0, 0), 0);

      // R8 cumulative budgets
      wr(mk(1, 0, 1, 3, 0), 0);
      for (int k = 0; k < 3; k++) begin
         go_count(n);
         check("R8 program within budget", n, 10);
      end
      check("R8 no error yet", int'(reg_rdata[9]), 0);
      go_count(n);
      check("R8 program refused", n, 0);
      check("R8 error flag", int'(reg_rdata[9]), 1);
      wr(mk(1, 1, 1, 3, 0), 0);
      go_count(n);
      check("R8 erase 1", n, 20);
      go_count(n);
      check("R8 erase 2", n, 20);
      go_count(n);
      check("R8 erase truncated", n, 10);
      go_count(n);
      check("R8 erase refused", n, 0);

      // R9 leaving writing mode clears totals and error
      wr(mk(0, 0, 0, 0, 0), 0);
      check("R9 error cleared", int'(reg_rdata[9]), 0);
      wr(mk(1, 0, 1, 3, 0), 0);
      go_count(n);
      check("R9 program after clear", n, 10);
      wr(mk(1, 1, 1, 3, 0), 0);
      go_count(n);
      check("R9 erase after clear", n, 20);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule